// File: doc/BRIEF.md
# Supervisory Cycle Priority Arbiter

This block sits between the operator panel and the machine's clock generator. Panel events such as a deposit press, an examine press, run, halt, a spare auxiliary task, a next-address press and a change of the displayed-register selection are each held as a sticky pending task. While any task is pending, the block raises a request for a supervisory cycle. When the clock generator grants that cycle, the block takes the most urgent pending task, registers it, and drives exactly one task strobe for one cycle so the rest of the panel logic knows which action to perform.

The next-address operation adds four to the memory address register in two granted cycles. Stage one writes the incremented address into the panel's scratch register. Stage two copies it back. The block raises stage two by itself when stage one completes. It also holds off the scratch register's parallel switch load from the end of stage one until stage two has fired.

The cycle request and grant form a valid/ready pair with no payload. The request stays high until a grant is seen. A grant that arrives while the request is low is ignored. The request never drops without a grant, because only a grant retires a pending task.

Top module: `sc_arb`

## Requirements
- R1: After reset `cyc_req_o`, `strb_o` and `sw_hold_o` are all low. `cyc_req_o` is high exactly when at least one task is pending.
- R2: A one-cycle pulse on `evt_i[k]` makes task k pending, so `cyc_req_o` is high in the next cycle. The event bit encoding is: 0 selection refresh, 1 auxiliary, 2 deposit, 3 examine, 4 run, 5 halt, 6 next-address.
- R3: In a cycle with `cyc_req_o` and `cyc_gnt_i` both high, the pending task with the highest index wins. `strb_o[index]` is high for exactly the following cycle. Index 7 is next-address stage two, which ranks above all event indices of R2.
- R4: A `cyc_gnt_i` seen while `cyc_req_o` is low produces no strobe.
- R5: `strb_o` has at most one bit set. It is all zero in any cycle not preceded by a grant.
- R6: A pending task remains pending, and `cyc_req_o` stays high, until that task wins a grant. It is then cleared. A new event for the same task in the grant cycle leaves it pending again.
- R7: A stage-one strobe (`strb_o[6]`) makes stage two (index 7) pending in the next cycle. Nothing else sets stage two.
- R8: `sw_hold_o` rises in the cycle after the stage-one strobe. It stays high up to and including the stage-two strobe cycle, and is low in the cycle after that.
- R9: A next-address event is ignored while a next-address operation is under way. That window runs from the cycle its stage one is pending up to the last cycle `sw_hold_o` is high.
- R10: A grant taken while stage two is pending always selects stage two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | One-cycle panel event pulses, bit encoding as in R2 |
| cyc_gnt_i | input | 1 | Supervisory cycle grant (ready) from the clock generator |
| cyc_req_o | output | 1 | Supervisory cycle request (valid) to the clock generator |
| strb_o | output | 8 | One-hot task strobes, bit index equals task index |
| sw_hold_o | output | 1 | Suppresses the scratch register's switch load |

## Verification
Directed patterns pit two simultaneous events against each other to show that ordering follows index rather than arrival. They also grant with nothing pending, which tells a true idle apart from a stale strobe. A re-event lands in its own grant cycle, which tells set-wins from clear-wins. A full next-address run has a deposit waiting and a second next-address press during the hold window; this shows stage two jumping ahead and the press being dropped. Long constrained-random runs with sparse events and a half-rate grant cover crowded queues and starved requests. In these runs every output is compared each cycle against a bench reference.

// File: rtl/sc_arb_pkg.sv
package sc_arb_pkg;
  localparam int NLINES = 8;
  localparam int IDX_W  = $clog2(NLINES);
  localparam int NEVT   = NLINES - 1;

  typedef logic [IDX_W-1:0] idx_t;

  // task indices; higher index is more urgent
  localparam idx_t T_SEL = idx_t'(0);
  localparam idx_t T_AUX = idx_t'(1);
  localparam idx_t T_DEP = idx_t'(2);
  localparam idx_t T_EXA = idx_t'(3);
  localparam idx_t T_RUN = idx_t'(4);
  localparam idx_t T_HLT = idx_t'(5);
  localparam idx_t T_NA1 = idx_t'(6);
  localparam idx_t T_NA2 = idx_t'(7);
endpackage

// File: rtl/sc_pend_bank.sv
module sc_pend_bank #(
  parameter int N = sc_arb_pkg::NLINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_line
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (set_i[k]) bit_q <= 1'b1;   // set wins over clear
      else if (clr_i[k]) bit_q <= 1'b0;
    end
    assign pend_o[k] = bit_q;
  end
endmodule

// File: rtl/sc_prio_enc.sv
module sc_prio_enc #(
  parameter int N = sc_arb_pkg::NLINES,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k]) idx_o = W'(k);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/sc_task_dec.sv
module sc_task_dec #(
  parameter int N = sc_arb_pkg::NLINES,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] idx_i,
  output logic [N-1:0] strb_o
);
  logic         vld_q;
  logic [W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= load_i;
      if (load_i) idx_q <= idx_i;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_strb
    assign strb_o[k] = vld_q && (idx_q == W'(k));
  end
endmodule

// File: rtl/sc_nxt_seq.sv
module sc_nxt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic s1_done_i,
  input  logic s2_done_i,
  output logic hold_o
);
  logic hold_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= 1'b0;
    else if (s1_done_i) hold_q <= 1'b1;
    else if (s2_done_i) hold_q <= 1'b0;
  end
  assign hold_o = hold_q;
endmodule

// File: rtl/sc_arb.sv
module sc_arb
  import sc_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEVT-1:0]   evt_i,
  input  logic              cyc_gnt_i,
  output logic              cyc_req_o,
  output logic [NLINES-1:0] strb_o,
  output logic              sw_hold_o
);
  logic [NLINES-1:0] pend_q;
  logic [NLINES-1:0] set_v;
  logic [NLINES-1:0] clr_v;
  logic              any_w;
  idx_t              win_w;
  logic              fire_w;
  logic              na_busy;

  sc_prio_enc #(.N(NLINES), .W(IDX_W)) u_enc (
    .req_i (pend_q),
    .any_o (any_w),
    .idx_o (win_w)
  );

  assign cyc_req_o = any_w;
  assign fire_w    = any_w && cyc_gnt_i;

  // a next-address operation occupies the panel until its hold drops
  assign na_busy = pend_q[T_NA1] || pend_q[T_NA2] || sw_hold_o || strb_o[T_NA1];

  always_comb begin
    set_v            = '0;
    set_v[NEVT-1:0]  = evt_i;
    set_v[T_NA1]     = evt_i[T_NA1] && !na_busy;
    set_v[T_NA2]     = strb_o[T_NA1];
    clr_v            = fire_w ? (NLINES'(1) << win_w) : '0;
  end

  sc_pend_bank #(.N(NLINES)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .pend_o (pend_q)
  );

  sc_task_dec #(.N(NLINES), .W(IDX_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (fire_w),
    .idx_i  (win_w),
    .strb_o (strb_o)
  );

  sc_nxt_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_done_i (strb_o[T_NA1]),
    .s2_done_i (strb_o[T_NA2]),
    .hold_o    (sw_hold_o)
  );
endmodule

// File: rtl/sc_arb_chk.sv
module sc_arb_chk
  import sc_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NEVT-1:0]   evt_i,
  input logic              cyc_gnt_i,
  input logic              cyc_req_o,
  input logic [NLINES-1:0] strb_o,
  input logic              sw_hold_o,
  input logic [NLINES-1:0] pend_q
);
  // R1
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_req_o && evt_i == '0 && !strb_o[T_NA1]) |=> !cyc_req_o);
  // R4
  no_gnt_no_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_req_o && cyc_gnt_i) |=> strb_o == '0);
  // R3
  gnt_gives_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req_o && cyc_gnt_i) |=> $countones(strb_o) == 1);
  // R5
  strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb_o));
  // R6
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req_o && !cyc_gnt_i) |=> cyc_req_o);
  // R7
  s2_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_o[T_NA1] |=> pend_q[T_NA2]);
  // R8
  hold_at_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_o[T_NA2] |-> sw_hold_o);
  // R8
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_hold_o) |-> $past(strb_o[T_NA2]));
  // R10
  s2_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[T_NA2] && cyc_req_o && cyc_gnt_i) |=> strb_o[T_NA2]);
endmodule

bind sc_arb sc_arb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .cyc_gnt_i (cyc_gnt_i),
  .cyc_req_o (cyc_req_o),
  .strb_o    (strb_o),
  .sw_hold_o (sw_hold_o),
  .pend_q    (pend_q)
);

// File: tb/sc_arb_tb.sv
module sc_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic       gnt = 1'b0;
  logic       req;
  logic [7:0] strb;
  logic       hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_pend;
  logic       m_tv;
  logic [2:0] m_ti;
  logic       m_hold;

  always #4 clk = ~clk;

  sc_arb u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .cyc_gnt_i (gnt),
    .cyc_req_o (req),
    .strb_o    (strb),
    .sw_hold_o (hold)
  );

  function automatic logic [7:0] exp_strb();
    return m_tv ? (8'd1 << m_ti) : 8'd0;
  endfunction

  function automatic logic [2:0] top_idx(input logic [7:0] p);
    logic [2:0] r = '0;
    for (int k = 0; k < 8; k++) if (p[k]) r = 3'(k);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [6:0] e, input logic g);
    logic [7:0] np;
    logic       fire, busy, s1, s2;
    logic [2:0] w;
    fire = (|m_pend) && g;
    w    = top_idx(m_pend);
    s1   = m_tv && m_ti == 3'd6;
    s2   = m_tv && m_ti == 3'd7;
    busy = m_pend[6] || m_pend[7] || m_hold || s1;
    np = m_pend;
    if (fire) np[w] = 1'b0;
    for (int k = 0; k < 6; k++) if (e[k]) np[k] = 1'b1;
    if (e[6] && !busy) np[6] = 1'b1;
    if (s1) np[7] = 1'b1;
    m_pend = np;
    if (s1) m_hold = 1'b1;
    else if (s2) m_hold = 1'b0;
    m_tv = fire;
    if (fire) m_ti = w;
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input logic [6:0] e, input logic g);
    evt = e;
    gnt = g;
    model_step(e, g);
    @(negedge clk);
    chk("R1 request", 32'(req), 32'(|m_pend));
    chk("R3 strobe", 32'(strb), 32'(exp_strb()));
    chk("R8 hold", 32'(hold), 32'(m_hold));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_pend = '0; m_tv = 1'b0; m_ti = '0; m_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R5 reset state
    chk("R1 reset req", 32'(req), 0);
    chk("R5 reset strobe", 32'(strb), 0);
    chk("R8 reset hold", 32'(hold), 0);

    // R2 R3: deposit and halt together, halt must come first
    step(7'h24, 1'b0);
    chk("R2 req after event", 32'(req), 1);
    step(7'h00, 1'b1);
    chk("R3 halt first", 32'(strb), 32'h20);
    step(7'h00, 1'b1);
    chk("R3 deposit second", 32'(strb), 32'h04);
    chk("R1 queue empty", 32'(req), 0);
    // R4 grant while idle
    step(7'h00, 1'b1);
    chk("R4 idle grant", 32'(strb), 0);

    // R6 request held without grant, then re-event in grant cycle
    step(7'h01, 1'b0);
    step(7'h00, 1'b0);
    step(7'h00, 1'b0);
    chk("R6 held req", 32'(req), 1);
    chk("R5 no grant no strobe", 32'(strb), 0);
    step(7'h01, 1'b1);
    chk("R6 refresh strobe", 32'(strb), 32'h01);
    chk("R6 re-event pending", 32'(req), 1);
    step(7'h00, 1'b1);
    chk("R6 second refresh", 32'(strb), 32'h01);
    chk("R6 cleared", 32'(req), 0);

    // R7 R8 R9 R10: next-address with deposit waiting
    step(7'h40, 1'b0);
    step(7'h04, 1'b1);
    chk("R3 stage one wins", 32'(strb), 32'h40);
    chk("R8 hold not yet", 32'(hold), 0);
    step(7'h00, 1'b0);
    chk("R8 hold raised", 32'(hold), 1);
    chk("R7 stage two pending", 32'(req), 1);
    step(7'h40, 1'b1);
    chk("R10 stage two first", 32'(strb), 32'h80);
    chk("R8 hold at stage two", 32'(hold), 1);
    step(7'h00, 1'b1);
    chk("R3 deposit after", 32'(strb), 32'h04);
    chk("R8 hold released", 32'(hold), 0);
    chk("R9 press ignored", 32'(req), 0);

    // constrained random: sparse events, half-rate grant
    for (int i = 0; i < 6000; i++) begin
      logic [6:0] e;
      e = '0;
      for (int k = 0; k < 7; k++) if ($urandom_range(0, 9) == 0) e[k] = 1'b1;
      step(e, 1'($urandom_range(0, 1)));
    end
    // drain
    for (int i = 0; i < 20; i++) step(7'h00, 1'b1);
    chk("R1 drained", 32'(req), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule